// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Serial Bus

This block is a slave on a two-wire serial bus. It holds a small bank of eight byte-wide clock-configuration registers, and a host reaches them with indexed block transfers. For a write, the host sends the write address byte, a starting index, a byte count and then the data bytes. The slave stores the data bytes from the index upward. For a read, the host writes only the starting index and then issues a repeated start with the read address byte. The slave first returns a byte count and then the register contents, starting at that index.

The pins are split the usual open-drain way. SCL and SDA come in as plain inputs, and the slave pulls SDA low through an output-enable. Both inputs pass through a two-flop synchroniser and a glitch filter before any edge is decoded. A start or a stop at any point returns the slave to a known state. The four lowest registers are placeholders: they accept writes and always read as zero. Register 4 holds the frequency-select controls and comes out of reset at a non-zero default.

Top module: `smbRegBank`

## Requirements
- R1: After reset, `sdaOe` is low and every register reads 0x00, except register 4, which reads 0x2C.
- R2: The slave acknowledges the address byte 0xD2 (write) and the address byte 0xD3 (read) by pulling SDA low during the ninth clock.
- R3: In a write, the slave acknowledges the index, count and data bytes. The index is taken modulo 8. Each stored data byte goes to the register the pointer names, and the pointer then advances by one.
- R4: Registers 0 to 3 accept writes without any change and always return 0x00.
- R5: A read made of write address, index N, repeated start and read address returns first a byte count of 0x08, then registers N, N+1 and so on, for as long as the host acknowledges.
- R6: The register pointer wraps from 7 to 0 during reads and writes.
- R7: Data bytes beyond the received byte count are acknowledged but change no register.
- R8: When the host does not acknowledge a returned byte, the slave releases SDA and keeps it released on further clocks until the next start or stop.
- R9: A start condition inside a byte discards the partial byte and begins a new address phase. The interrupted data byte is not stored.
- R10: A low pulse on SDA lasting one system clock while SCL is high is seen neither as a start nor as a stop, so the transfer in progress completes normally.
- R11: An address byte other than 0xD2 or 0xD3 gets no acknowledge, and the slave then leaves SDA released for the rest of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus lines are sampled on it |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| regsOut | output | 64 | Register contents, register i in bits [8i+7:8i] |

## Verification
The bench checks the cases where a slave most easily loses track of the pointer or of the bus. It reads across the top of the bank; a slave that did not wrap would return stale or shifted bytes. It writes one byte more than the count; a slave that ignored the count would corrupt the next register. It interrupts a byte with a repeated start; a slave that did not reset its bit counter would commit a half-shifted byte. It injects a one-cycle SDA spike while SCL is high; a slave without a filter would abort the write. After a host NACK it keeps clocking and checks that SDA stays released, which catches a slave that goes on driving the next byte onto the bus.

// File: rtl/smbRegPkg.sv
package smbRegPkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_RXACK, PH_TX, PH_TXACK, PH_WAIT
  } phase_t;

  typedef enum logic [1:0] {
    ST_ADDR, ST_INDEX, ST_COUNT, ST_DATA
  } stage_t;

  typedef struct packed {
    logic setIndex;
    logic setCount;
    logic wrData;
    logic loadCnt;
    logic loadData;
    logic shiftTx;
  } dpStrobe_t;
endpackage

// File: rtl/smbRegData.sv
module smbRegData
  import smbRegPkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int RSVD_REGS = 4,
  parameter int CFG_IDX = 4,
  parameter logic [BYTE_W-1:0] CFG_DEFAULT = 8'h2C
) (
  input  logic clk,
  input  logic rstN,
  input  dpStrobe_t stb,
  input  logic [BYTE_W-1:0] rxByte,
  output logic txBit,
  output logic [NUM_REGS*BYTE_W-1:0] regsOut
);
  localparam int PTR_W = $clog2(NUM_REGS);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  logic [PTR_W-1:0] ptr;
  logic [BYTE_W-1:0] left;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] regView [NUM_REGS];
  logic wrEn;
  logic [PTR_W-1:0] ptrNext;

  assign wrEn = stb.wrData && (left != '0);
  assign ptrNext = (ptr == LAST) ? '0 : ptr + PTR_W'(1);
  assign txBit = txShift[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      left <= '0;
      txShift <= '0;
    end else begin
      if (stb.setIndex) ptr <= PTR_W'(rxByte % BYTE_W'(NUM_REGS));
      else if (wrEn || stb.loadData) ptr <= ptrNext;
      if (stb.setCount) left <= rxByte;
      else if (wrEn) left <= left - BYTE_W'(1);
      if (stb.loadCnt) txShift <= BYTE_W'(NUM_REGS);
      else if (stb.loadData) txShift <= regView[ptr];
      else if (stb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    if (i < RSVD_REGS) begin : gRsvd
      assign regView[i] = '0;
    end else begin : gLive
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= (i == CFG_IDX) ? CFG_DEFAULT : '0;
        else if (wrEn && ptr == PTR_W'(i)) q <= rxByte;
      end
      assign regView[i] = q;
    end
    assign regsOut[i*BYTE_W +: BYTE_W] = regView[i];
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ((wrEn || stb.loadData) && ptr == LAST) |=> (ptr == '0)); // R6
  AST_EXCESS_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrData && left == '0) |=> $stable(regsOut)); // R7
  AST_COUNT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (left == $past(left) - BYTE_W'(1))); // R7
endmodule

// File: rtl/smbRegCtrl.sv
module smbRegCtrl
  import smbRegPkg::*;
#(
  parameter int FILT_LEN = 3,
  parameter logic [BYTE_W-1:0] WR_ADDR = 8'hD2,
  parameter logic [BYTE_W-1:0] RD_ADDR = 8'hD3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic txBit,
  output logic [BYTE_W-1:0] rxByte,
  output dpStrobe_t stb,
  output logic sdaOe
);
  localparam int FCW = $clog2(FILT_LEN + 1);

  logic [1:0] sclSync, sdaSync;
  logic [1:0] raw, filt;
  logic sclF, sdaF, sclP, sdaP;
  logic startDet, stopDet, sclRise, sclFall;
  phase_t phase;
  stage_t stage;
  logic [3:0] bitCnt;
  logic [2:0] txCnt;
  logic [BYTE_W-1:0] shiftIn;
  logic isRead, hostAck, rxDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
    end
  end

  assign raw = {sclSync[1], sdaSync[1]};

  for (genvar g = 0; g < 2; g++) begin : gFilt
    logic [FCW-1:0] fcnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        filt[g] <= 1'b1;
        fcnt <= '0;
      end else if (raw[g] == filt[g]) begin
        fcnt <= '0;
      end else if (fcnt == FCW'(FILT_LEN - 1)) begin
        filt[g] <= raw[g];
        fcnt <= '0;
      end else begin
        fcnt <= fcnt + FCW'(1);
      end
    end
  end

  assign sclF = filt[1];
  assign sdaF = filt[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclF;
      sdaP <= sdaF;
    end
  end

  assign startDet = sclF && sclP && sdaP && !sdaF;
  assign stopDet = sclF && sclP && !sdaP && sdaF;
  assign sclRise = sclF && !sclP;
  assign sclFall = !sclF && sclP;
  assign rxDone = (phase == PH_RX) && sclFall && (bitCnt == 4'd8);
  assign rxByte = shiftIn;

  always_comb begin
    stb = '0;
    if (!startDet && !stopDet) begin
      stb.setIndex = rxDone && stage == ST_INDEX;
      stb.setCount = rxDone && stage == ST_COUNT;
      stb.wrData = rxDone && stage == ST_DATA;
      stb.loadCnt = (phase == PH_RXACK) && sclFall && isRead;
      stb.loadData = (phase == PH_TXACK) && sclFall && hostAck;
      stb.shiftTx = (phase == PH_TX) && sclFall && (txCnt != 3'd7);
    end
  end

  assign sdaOe = (phase == PH_RXACK) || (phase == PH_TX && !txBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      stage <= ST_ADDR;
      bitCnt <= '0;
      txCnt <= '0;
      shiftIn <= '0;
      isRead <= 1'b0;
      hostAck <= 1'b0;
    end else if (startDet) begin
      phase <= PH_RX;
      stage <= ST_ADDR;
      bitCnt <= '0;
      isRead <= 1'b0;
    end else if (stopDet) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_RX: begin
          if (sclRise) begin
            shiftIn <= {shiftIn[BYTE_W-2:0], sdaF};
            bitCnt <= bitCnt + 4'd1;
          end
          if (rxDone) begin
            phase <= PH_RXACK;
            case (stage)
              ST_ADDR: begin
                isRead <= (shiftIn == RD_ADDR);
                stage <= ST_INDEX;
                if (shiftIn != WR_ADDR && shiftIn != RD_ADDR) phase <= PH_WAIT;
              end
              ST_INDEX: stage <= ST_COUNT;
              default: stage <= ST_DATA;
            endcase
          end
        end
        PH_RXACK: if (sclFall) begin
          phase <= isRead ? PH_TX : PH_RX;
          bitCnt <= '0;
          txCnt <= '0;
        end
        PH_TX: if (sclFall) begin
          if (txCnt == 3'd7) phase <= PH_TXACK;
          else txCnt <= txCnt + 3'd1;
        end
        PH_TXACK: begin
          if (sclRise) hostAck <= !sdaF;
          if (sclFall) begin
            phase <= hostAck ? PH_TX : PH_WAIT;
            txCnt <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclF); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)); // R3
  AST_QUIET_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WAIT || phase == PH_IDLE) |-> !sdaOe); // R11
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (phase == PH_RX && bitCnt == 4'd0 && stage == ST_ADDR)); // R9
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_TXACK && sclFall && !hostAck && !startDet && !stopDet)
      |=> (phase == PH_WAIT && !sdaOe)); // R8
endmodule

// File: rtl/smbRegBank.sv
module smbRegBank
  import smbRegPkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int RSVD_REGS = 4,
  parameter int CFG_IDX = 4,
  parameter logic [7:0] CFG_DEFAULT = 8'h2C,
  parameter int FILT_LEN = 3,
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe,
  output logic [NUM_REGS*8-1:0] regsOut
);
  dpStrobe_t stb;
  logic [BYTE_W-1:0] rxByte;
  logic txBit;

  smbRegCtrl #(
    .FILT_LEN(FILT_LEN), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .txBit(txBit), .rxByte(rxByte), .stb(stb), .sdaOe(sdaOe)
  );

  smbRegData #(
    .NUM_REGS(NUM_REGS), .RSVD_REGS(RSVD_REGS),
    .CFG_IDX(CFG_IDX), .CFG_DEFAULT(CFG_DEFAULT)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .rxByte(rxByte),
    .txBit(txBit), .regsOut(regsOut)
  );
endmodule

// File: tb/tb_smbRegBank.sv
module tb_smbRegBank;
  localparam int H = 20;
  localparam int NV = 7;
  // {index, data written, value expected back}
  localparam logic [23:0] VEC [NV] = '{
    {8'd4, 8'h5A, 8'h5A}, {8'd5, 8'hC3, 8'hC3}, {8'd7, 8'h81, 8'h81},
    {8'd2, 8'hFF, 8'h00}, {8'd6, 8'h3C, 8'h3C}, {8'd0, 8'h77, 8'h00},
    {8'd12, 8'h99, 8'h99}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostScl = 1'b1;
  logic hostSda = 1'b1;
  logic sdaOe;
  logic [63:0] regsOut;
  logic sdaBus;
  int nChecks = 0;
  int nFails = 0;
  logic [7:0] expR [8];

  assign sdaBus = hostSda & ~sdaOe;
  always #5 clk = ~clk;

  smbRegBank dut (
    .clk(clk), .rstN(rstN), .sclIn(hostScl), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .regsOut(regsOut)
  );

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expVec();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = expR[i];
    return v;
  endfunction

  task automatic chkRegs(input string req);
    chk(regsOut === expVec(), req, regsOut, expVec());
  endtask

  task automatic modelWrite(input logic [7:0] idx, input logic [7:0] cnt, input logic [31:0] d, input int n);
    int p = idx % 8;
    for (int i = 0; i < n; i++) begin
      if (i < cnt) begin
        if (p >= 4) expR[p] = d[(3-i)*8 +: 8];
        p = (p + 1) % 8;
      end
    end
  endtask

  task automatic hStart();
    hostSda = 1'b1; waitC(H);
    hostScl = 1'b1; waitC(H);
    hostSda = 1'b0; waitC(H);
    hostScl = 1'b0; waitC(H);
  endtask

  task automatic hStop();
    hostSda = 1'b0; waitC(H);
    hostScl = 1'b1; waitC(H);
    hostSda = 1'b1; waitC(H);
  endtask

  task automatic hBits(input logic [7:0] b, input int nb, input logic glitch);
    for (int i = 7; i > 7 - nb; i--) begin
      hostSda = b[i]; waitC(H);
      hostScl = 1'b1;
      if (glitch && i == 7) begin
        waitC(H/2); hostSda = 1'b0; waitC(1); hostSda = 1'b1; waitC(H/2 - 1);
      end else waitC(H);
      hostScl = 1'b0;
    end
  endtask

  task automatic hWrite(input logic [7:0] b, input logic glitch, output logic ack);
    hBits(b, 8, glitch);
    hostSda = 1'b1; waitC(H);
    hostScl = 1'b1; waitC(H/2);
    ack = ~sdaBus; waitC(H/2);
    hostScl = 1'b0;
  endtask

  task automatic hRead(output logic [7:0] b, input logic ackIt);
    hostSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitC(H); hostScl = 1'b1; waitC(H/2);
      b[i] = sdaBus; waitC(H/2); hostScl = 1'b0;
    end
    hostSda = ackIt ? 1'b0 : 1'b1; waitC(H);
    hostScl = 1'b1; waitC(H);
    hostScl = 1'b0; hostSda = 1'b1;
  endtask

  task automatic wrTxn(input logic [7:0] idx, input logic [7:0] cnt, input logic [31:0] d,
                       input int n, output logic allAck);
    logic a;
    allAck = 1'b1;
    hStart();
    hWrite(8'hD2, 1'b0, a); allAck &= a;
    hWrite(idx, 1'b0, a); allAck &= a;
    hWrite(cnt, 1'b0, a); allAck &= a;
    for (int i = 0; i < n; i++) begin
      hWrite(d[(3-i)*8 +: 8], 1'b0, a); allAck &= a;
    end
    hStop();
    modelWrite(idx, cnt, d, n);
  endtask

  task automatic rdTxn(input logic [7:0] idx, input int n, output logic [7:0] cntB,
                       output logic [31:0] d, output logic allAck);
    logic a;
    logic [7:0] b;
    d = '0;
    allAck = 1'b1;
    hStart();
    hWrite(8'hD2, 1'b0, a); allAck &= a;
    hWrite(idx, 1'b0, a); allAck &= a;
    hStart();
    hWrite(8'hD3, 1'b0, a); allAck &= a;
    hRead(cntB, 1'b1);
    for (int i = 0; i < n; i++) begin
      hRead(b, i != n - 1);
      d[(3-i)*8 +: 8] = b;
    end
    hStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic ok, a;
    logic [7:0] c, b;
    logic [31:0] d;
    for (int i = 0; i < 8; i++) expR[i] = 8'h00;
    expR[4] = 8'h2C;
    waitC(5);
    chk(sdaOe === 1'b0, "R1 sdaOe in reset", 64'(sdaOe), 64'd0);
    rstN = 1'b1;
    waitC(5);
    chkRegs("R1 reset registers");
    chk(sdaOe === 1'b0, "R1 sdaOe after reset", 64'(sdaOe), 64'd0);

    // R1/R4/R5: read reg3 (reserved) and reg4 (default) over the bus
    rdTxn(8'd3, 2, c, d, ok);
    chk(ok, "R2 read path acks", 64'(ok), 64'd1);
    chk(c == 8'h08, "R5 byte count", 64'(c), 64'h08);
    chk(d[31:16] == 16'h002C, "R1 R4 bus readback", 64'(d[31:16]), 64'h002C);

    // Table walk: single-byte writes then reads
    for (int v = 0; v < NV; v++) begin
      wrTxn(VEC[v][23:16], 8'd1, {VEC[v][15:8], 24'h0}, 1, ok);
      chk(ok, "R2 R3 write acks", 64'(ok), 64'd1);
      chkRegs("R3 R4 register image");
      rdTxn(VEC[v][23:16], 1, c, d, ok);
      chk(c == 8'h08, "R5 byte count", 64'(c), 64'h08);
      chk(d[31:24] == VEC[v][7:0], "R3 R4 R5 readback", 64'(d[31:24]), 64'(VEC[v][7:0]));
    end

    // R3: pointer advances over a multi-byte write
    wrTxn(8'd5, 8'd3, 32'h11223300, 3, ok);
    chk(ok, "R3 multi-byte acks", 64'(ok), 64'd1);
    chkRegs("R3 multi-byte write");

    // R6: read across the top of the bank
    rdTxn(8'd6, 4, c, d, ok);
    chk(d == 32'h22330000, "R6 read wrap", 64'(d), 64'h22330000);

    // R7: one data byte past the count
    wrTxn(8'd4, 8'd1, 32'h66770000, 2, ok);
    chk(ok, "R7 excess byte acked", 64'(ok), 64'd1);
    chkRegs("R7 excess byte dropped");
    chk(regsOut[47:40] == 8'h11, "R7 reg5 untouched", 64'(regsOut[47:40]), 64'h11);

    // R11: foreign address
    hStart();
    hWrite(8'hA0, 1'b0, a);
    chk(a == 1'b0, "R11 foreign address no ack", 64'(a), 64'd0);
    hWrite(8'h04, 1'b0, a);
    chk(a == 1'b0, "R11 following byte no ack", 64'(a), 64'd0);
    hStop();
    chkRegs("R11 registers unchanged");

    // R8: NACK releases SDA, more clocks leave it released
    hStart();
    hWrite(8'hD2, 1'b0, a);
    hWrite(8'h05, 1'b0, a);
    hStart();
    hWrite(8'hD3, 1'b0, a);
    hRead(c, 1'b1);
    hRead(b, 1'b0);
    chk(b == 8'h11, "R5 reg5 data", 64'(b), 64'h11);
    ok = 1'b1;
    for (int k = 0; k < 9; k++) begin
      waitC(H); hostScl = 1'b1; waitC(H/2);
      if (sdaBus !== 1'b1) ok = 1'b0;
      waitC(H/2); hostScl = 1'b0;
    end
    chk(ok, "R8 SDA released after NACK", 64'(ok), 64'd1);
    hStop();

    // R9: repeated start inside a data byte
    hStart();
    hWrite(8'hD2, 1'b0, a);
    hWrite(8'h06, 1'b0, a);
    hWrite(8'h01, 1'b0, a);
    hBits(8'hF0, 4, 1'b0);
    hStart();
    hStop();
    chkRegs("R9 partial byte dropped");
    chk(regsOut[55:48] == 8'h22, "R9 reg6 kept", 64'(regsOut[55:48]), 64'h22);

    // R10: one-cycle SDA glitch during SCL high
    hStart();
    hWrite(8'hD2, 1'b0, a);
    hWrite(8'h05, 1'b0, a);
    hWrite(8'h01, 1'b0, a);
    hWrite(8'hFF, 1'b1, a);
    chk(a == 1'b1, "R10 byte after glitch acked", 64'(a), 64'd1);
    hStop();
    expR[5] = 8'hFF;
    chkRegs("R10 write survives glitch");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule